// File: doc/BRIEF.md
# Sticky Fault Flag Bank

This block keeps a latched record of live fault flags so that a fault lasting a single cycle is still seen by software reading it much later. The live flags arrive as one vector that is split into five 8-bit groups. Each group has a sticky register: any bit that is high in the live group sets the matching sticky bit, and the sticky bit stays set after the live flag goes away. The live flags themselves pass through the block unchanged and are not affected by it.

Software reads a sticky register through a small port made of an address, a read strobe and a data output. The data shows the register value before any clear. A strobed read then clears only those bits of that register whose live fault has gone away. Two power-on request inputs, one per output channel, also clear the registers. Each one clears its own channel's register and the three shared registers, and leaves the other channel's register alone. These inputs may be asynchronous. Only a rising edge counts as a request.

Top module: `sticky_flag_bank`

## Requirements
- R1: A live flag bit that is high at a rising clock edge makes the matching sticky bit read as 1 after that edge. Register n holds live bits flagsLive[8n+7:8n], for n from 0 to 4.
- R2: When no clear is applied, a sticky bit that is set stays set after its live flag returns low.
- R3: rdData shows, without delay, the current sticky value of the register selected by rdAddr. During a strobed read it is the value from before the clear.
- R4: A strobed read of register 0 to 4 clears, at that clock edge, the register's bits whose live flag is low. Bits whose live flag is high stay set.
- R5: Addresses 5 to 7 read as zero, and a strobed read of such an address clears nothing.
- R6: A rising edge on powerOnReqA clears registers 0, 2, 3 and 4 at the third rising clock edge after the input rises. Register 1 is unchanged.
- R7: A rising edge on powerOnReqB clears registers 1, 2, 3 and 4 with the same latency as R6. Register 0 is unchanged.
- R8: When a live flag is high at the same edge as a read clear or a power-on clear, its sticky bit is set after that edge.
- R9: A power-on request held high clears the registers once only. Flags latched while it stays high are kept.
- R10: After reset, every sticky register reads zero.
- R11: A strobed read changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flagsLive | input | 40 | Live fault flags, 8 bits per register |
| rdAddr | input | 3 | Register select for the read port |
| rdStrobe | input | 1 | Read strobe; marks a read that clears |
| powerOnReqA | input | 1 | Channel A power-on request, asynchronous |
| powerOnReqB | input | 1 | Channel B power-on request, asynchronous |
| rdData | output | 8 | Value of the selected sticky register |

## Verification
The hardest case to reach from the ports is a live flag that is high on exactly the edge where a power-on clear takes effect. That edge comes three cycles after an asynchronous input rises. The stimulus raises the request and holds a live flag high across the whole synchronizer window, so the clear and the set must fall on the same edge. The timing is checked separately by holding the read address on a shared register and sampling it just before and just after the third edge. The read-clear collision is reached by driving a live flag and a strobed read in the same cycle, on a register whose other bits are already set.

// File: rtl/sff_pkg.sv
package sff_pkg;
  parameter int unsigned NUM_REGS = 5;
  parameter int unsigned REG_W    = 8;
  parameter int unsigned NUM_CHAN = 2;
  parameter int unsigned SYNC_STAGES = 2;
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);
  localparam int unsigned FLAG_W = NUM_REGS * REG_W;

  // Registers cleared by each channel's power-on request (bit n = register n).
  // Channel 0 (A) spares register 1, channel 1 (B) spares register 0.
  parameter logic [NUM_CHAN-1:0][NUM_REGS-1:0] CLR_MAP = {5'b11110, 5'b11101};

  typedef struct packed {
    logic [NUM_REGS-1:0] chanClr;
    logic [NUM_REGS-1:0] readClr;
  } sffStrobes_t;
endpackage

// File: rtl/sff_edge_sync.sv
module sff_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEvt
);
  logic [STAGES-1:0] syncQ;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], asyncIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  // One-cycle pulse on a synchronized rising edge
  assign riseEvt = syncQ[STAGES-1] & ~lastQ;
endmodule

// File: rtl/sff_ctrl.sv
module sff_ctrl
  import sff_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CHAN-1:0] powerOnReq,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                rdStrobe,
  output sffStrobes_t         strobes
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [NUM_CHAN-1:0] chanEvt;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    sff_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (powerOnReq[c]),
      .riseEvt (chanEvt[c])
    );
  end

  always_comb begin
    strobes.chanClr = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (chanEvt[c]) strobes.chanClr = strobes.chanClr | CLR_MAP[c];
    end
    strobes.readClr = '0;
    if (rdStrobe && (rdAddr <= LAST_IDX)) strobes.readClr[rdAddr] = 1'b1;
  end
endmodule

// File: rtl/sff_datapath.sv
module sff_datapath
  import sff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flagsLive,
  input  sffStrobes_t       strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output logic [FLAG_W-1:0] stickyFlat
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [REG_W-1:0] stickyQ [NUM_REGS];
  logic [REG_W-1:0] nextVal [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic clrHit;
    assign clrHit = strobes.chanClr[g] | strobes.readClr[g];
    // Clear first, then merge the live flags so a fresh fault always survives
    assign nextVal[g] = (clrHit ? '0 : stickyQ[g]) | flagsLive[g*REG_W +: REG_W];
    assign stickyFlat[g*REG_W +: REG_W] = stickyQ[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) stickyQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) stickyQ[i] <= nextVal[i];
    end
  end

  assign rdData = (rdAddr <= LAST_IDX) ? stickyQ[rdAddr] : '0;
endmodule

// File: rtl/sticky_flag_bank.sv
module sticky_flag_bank
  import sff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] flagsLive,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobe,
  input  logic              powerOnReqA,
  input  logic              powerOnReqB,
  output logic [REG_W-1:0]  rdData
);
  sffStrobes_t       strobes;
  logic [FLAG_W-1:0] stickyFlat;

  sff_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerOnReq ({powerOnReqB, powerOnReqA}),
    .rdAddr     (rdAddr),
    .rdStrobe   (rdStrobe),
    .strobes    (strobes)
  );

  sff_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .flagsLive  (flagsLive),
    .strobes    (strobes),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .stickyFlat (stickyFlat)
  );
endmodule

// File: rtl/sticky_flag_bank_chk.sv
module sticky_flag_bank_chk
  import sff_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [FLAG_W-1:0] flagsLive,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdStrobe,
  input logic [REG_W-1:0]  rdData,
  input logic [FLAG_W-1:0] stickyFlat,
  input sffStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [REG_W-1:0] stickyArr [NUM_REGS];
  logic [REG_W-1:0] liveArr   [NUM_REGS];
  logic [ADDR_W-1:0] lastAddr;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_view
    assign stickyArr[g] = stickyFlat[g*REG_W +: REG_W];
    assign liveArr[g]   = flagsLive[g*REG_W +: REG_W];

    // R6, R7, R8: a power-on clear leaves exactly the live bits of that edge
    p_chanclr_r6_r7: assert property (@(posedge clk) disable iff (!rstN)
      strobes.chanClr[g] |=> (stickyArr[g] == $past(liveArr[g])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastAddr <= '0;
    else       lastAddr <= rdAddr;
  end

  p_set_visible_r1: assert property (@(posedge clk) disable iff (!rstN)
    (|flagsLive) |=> ((stickyFlat & $past(flagsLive)) == $past(flagsLive)));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes == '0) |=> ((stickyFlat & $past(stickyFlat)) == $past(stickyFlat)));

  // R4, R8: after a strobed read only live bits remain in that register
  p_read_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && (rdAddr <= LAST_IDX)) |=> (stickyArr[lastAddr] == $past(liveArr[rdAddr])));

  p_bad_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr > LAST_IDX) |-> ((rdData == '0) && (strobes.readClr == '0)));

  p_single_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.readClr));
endmodule

bind sticky_flag_bank sticky_flag_bank_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flagsLive  (flagsLive),
  .rdAddr     (rdAddr),
  .rdStrobe   (rdStrobe),
  .rdData     (rdData),
  .stickyFlat (stickyFlat),
  .strobes    (strobes)
);

// File: tb/sticky_flag_bank_tb.sv
module sticky_flag_bank_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NR = 5;
  localparam int RW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [NR*RW-1:0] flagsLive;
  logic [2:0] rdAddr;
  logic rdStrobe, powerOnReqA, powerOnReqB;
  logic [RW-1:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  sticky_flag_bank u_dut (
    .clk(clk), .rstN(rstN), .flagsLive(flagsLive), .rdAddr(rdAddr),
    .rdStrobe(rdStrobe), .powerOnReqA(powerOnReqA), .powerOnReqB(powerOnReqB),
    .rdData(rdData)
  );

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Behavioural reference: register contents plus pending clear countdowns
  int mdl [NR];
  int cntA = -1;
  int cntB = -1;
  bit lastA = 0;
  bit lastB = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NR; i++) mdl[i] = 0;
      cntA = -1; cntB = -1; lastA = 0; lastB = 0;
    end else begin
      bit fireA, fireB;
      fireA = (cntA == 1);
      fireB = (cntB == 1);
      if (cntA > 0) cntA--;
      if (cntB > 0) cntB--;
      if (powerOnReqA && !lastA) cntA = 2;
      if (powerOnReqB && !lastB) cntB = 2;
      lastA = powerOnReqA;
      lastB = powerOnReqB;
      for (int r = 0; r < NR; r++) begin
        bit clr;
        clr = (fireA && r != 1) || (fireB && r != 0) || (rdStrobe && int'(rdAddr) == r);
        mdl[r] = (clr ? 0 : mdl[r]) | int'(flagsLive[r*RW +: RW]);
      end
    end
  end

  // R3: compare the read port against the reference every cycle
  always @(negedge clk) begin
    #1;
    if (rstN === 1'b1 && !done) begin
      int expv;
      expv = (int'(rdAddr) < NR) ? mdl[rdAddr] : 0;
      check(int'(rdData) == expv, "R3", int'(rdData), expv);
    end
  end

  task automatic peek(int a, int expv, string req);
    @(negedge clk);
    rdAddr = 3'(a);
    rdStrobe = 1'b0;
    #1;
    check(int'(rdData) == expv, req, int'(rdData), expv);
  endtask

  task automatic readClr(int a, int expv, string req);
    @(negedge clk);
    rdAddr = 3'(a);
    rdStrobe = 1'b1;
    #1;
    check(int'(rdData) == expv, req, int'(rdData), expv);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulse(int r, int v);
    @(negedge clk);
    flagsLive[r*RW +: RW] = 8'(v);
    @(negedge clk);
    flagsLive[r*RW +: RW] = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; flagsLive = '0; rdAddr = '0; rdStrobe = 1'b0;
    powerOnReqA = 1'b0; powerOnReqB = 1'b0;
    idle(3);
    rstN = 1'b1;

    for (int a = 0; a < NR; a++) peek(a, 0, "R10");

    // Single-cycle pulses are latched and held
    pulse(0, 'h08);
    pulse(2, 'h80);
    idle(2);
    peek(0, 'h08, "R1");
    peek(2, 'h80, "R2");

    // Strobed read returns the old value, then clears
    readClr(0, 'h08, "R3");
    peek(0, 'h00, "R4");
    peek(2, 'h80, "R11");

    // Bit whose live fault persists survives the read
    pulse(1, 'h05);
    @(negedge clk);
    flagsLive[15:8] = 8'h04;
    readClr(1, 'h05, "R4");
    peek(1, 'h04, "R4");
    flagsLive[15:8] = 8'h00;
    idle(1);
    peek(1, 'h04, "R2");

    // Out-of-range address
    readClr(6, 0, "R5");
    peek(2, 'h80, "R5");
    peek(1, 'h04, "R5");

    // Channel A power-on clear and its latency
    pulse(0, 'h11);
    pulse(1, 'h22);
    pulse(2, 'h33);
    pulse(3, 'h44);
    pulse(4, 'h55);
    @(negedge clk);
    rdAddr = 3'd4;
    rdStrobe = 1'b0;
    @(negedge clk);
    powerOnReqA = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(int'(rdData) == 'h55, "R6", int'(rdData), 'h55);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(int'(rdData) == 0, "R6", int'(rdData), 0);
    peek(0, 'h00, "R6");
    peek(1, 'h26, "R6");
    peek(2, 'h00, "R6");
    peek(3, 'h00, "R6");

    // Held request clears only once
    pulse(0, 'h01);
    idle(4);
    peek(0, 'h01, "R9");
    powerOnReqA = 1'b0;
    idle(3);

    // Channel B clear, with a live flag held across the clear edge
    pulse(3, 'hF0);
    @(negedge clk);
    flagsLive[39:32] = 8'h80;
    powerOnReqB = 1'b1;
    idle(5);
    flagsLive[39:32] = 8'h00;
    peek(0, 'h01, "R7");
    peek(1, 'h00, "R7");
    peek(3, 'h00, "R7");
    peek(4, 'h80, "R8");

    // Live flag and strobed read on the same edge
    pulse(3, 'hF0);
    @(negedge clk);
    flagsLive[31:24] = 8'h0F;
    rdAddr = 3'd3;
    rdStrobe = 1'b1;
    #1;
    check(int'(rdData) == 'hF0, "R8", int'(rdData), 'hF0);
    @(negedge clk);
    rdStrobe = 1'b0;
    flagsLive[31:24] = 8'h00;
    peek(3, 'h0F, "R8");
    powerOnReqB = 1'b0;
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule